// File: doc/BRIEF.md
# Three-Voice Phase Accumulator Ring with Hard Sync

This block holds three phase accumulators, each 24 bits wide, that advance together on a shared clock enable. On every enabled cycle each accumulator adds its own 16-bit frequency word, and the sum wraps modulo 2^24. A per-voice test input forces the phase to zero and holds it there. When test is released, the voice counts up from zero again. Every enabled update also reports two one-cycle strobes per voice: one when the top phase bit goes from 0 to 1, and one when phase bit 19 goes from 0 to 1. The bit-19 strobe is meant to clock a noise generator outside this block.

The voices are wired as a fixed ring. Voice 0 takes its sync source from voice 2, voice 1 from voice 0, and voice 2 from voice 1. If a voice has sync enabled and its source's top bit rises, the voice's phase is cleared in that same update. The decision is made only after all three next-phase values are known, so the voices behave as if they run in parallel. There is one exception. If the source is itself being cleared by its own source in that same update, the clear is not passed on to the destination. For each voice the block also outputs a ring-modulated top bit: the voice's top phase bit XORed with the source's top bit when ring mode is on for that voice.

All pins are plain control and status signals. There is no streamed data path, so there is no valid/ready handshake and no back-pressure.

Top module: `phase_osc_ring`

## Requirements
- R1: While `rst` is high, every phase is cleared to zero and all strobes are low. The first sample after `rst` is released shows the same values.
- R2: On a clock edge with `step_en` high and `test` low for a voice, the voice's phase becomes (phase + freq) mod 2^24, unless R6 clears it. With `step_en` low, every phase is unchanged.
- R3: On an enabled edge with a voice's `test` bit high, that phase becomes zero. The first enabled edge after `test` falls loads exactly the frequency word.
- R4: `msb_rise[i]` is high for the one cycle after an enabled update in which phase bit 23 of voice i went from 0 to 1. It stays low when bit 23 falls on wrap-around. The flag reflects the unsynced sum, so it is still raised when the same update also clears that voice by sync.
- R5: `tap_rise[i]` marks a 0-to-1 change of phase bit 19 with the same timing rules as R4.
- R6: Sync sources form the ring 0←2, 1←0, 2←1. If the source's bit 23 rises in an update and the destination's `sync_en` bit is high, the destination's phase after that update is zero.
- R7: When a voice's `sync_en` bit is low, a rising top bit on its source leaves its phase at the R2 value.
- R8: The R6 clear is suppressed when the source has `sync_en` high and the source's own source also has a rising top bit in the same update.
- R9: `ring_msb[i]` equals phase bit 23 of voice i XOR (`ring_en[i]` AND phase bit 23 of the source of voice i).
- R10: Both strobes are low after any edge with `step_en` low, and low for a voice whose `test` bit was high at the update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| step_en | input | 1 | Shared update enable |
| freq | input | 48 | Frequency words, voice i in bits [16i+15:16i] |
| test | input | 3 | Per-voice clear-and-hold |
| sync_en | input | 3 | Per-voice hard sync enable |
| ring_en | input | 3 | Per-voice ring-modulation select |
| phase | output | 72 | Phases, voice i in bits [24i+23:24i] |
| msb_rise | output | 3 | Top-bit rising strobes |
| tap_rise | output | 3 | Bit-19 rising strobes |
| ring_msb | output | 3 | Ring-modulated top bits |

## Verification
A wrong phase in any voice shows up on `phase` one cycle after the faulty update. Because the error is accumulated, it never goes away. A missed or spurious sync clear, such as a broken suppression rule, makes the destination's phase differ from that point on. A bad rise detector shows up first on the strobes, and then indirectly through wrong sync decisions in the following voice. The bench therefore compares every voice's phase and strobes after every single cycle, so each fault is reported in the cycle where it first appears.

// File: rtl/osc_pkg.sv
package osc_pkg;
  localparam int unsigned PH_W_DEF   = 24;
  localparam int unsigned FQ_W_DEF   = 16;
  localparam int unsigned TAP_DEF    = 19;
  localparam int unsigned VOICES_DEF = 3;

  // ring source: each voice follows the one below it (wrapping)
  function automatic int unsigned ring_src(input int unsigned idx, input int unsigned n);
    return (idx + n - 1) % n;
  endfunction
endpackage

// File: rtl/phase_acc.sv
module phase_acc #(
  parameter int unsigned PH_W = osc_pkg::PH_W_DEF,
  parameter int unsigned FQ_W = osc_pkg::FQ_W_DEF,
  parameter int unsigned TAP  = osc_pkg::TAP_DEF
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            step_en,
  input  logic            test,
  input  logic [FQ_W-1:0] freq,
  input  logic            sync_clr,
  output logic [PH_W-1:0] acc,
  output logic            top_rise_now,
  output logic            top_rise_q,
  output logic            tap_rise_q
);
  localparam int unsigned TOP = PH_W - 1;

  logic [PH_W-1:0] sum;
  logic [PH_W-1:0] set_bits;

  always_comb begin
    sum      = test ? '0 : acc + PH_W'(freq);
    set_bits = ~acc & sum;
  end

  assign top_rise_now = set_bits[TOP];

  always_ff @(posedge clk) begin
    if (rst) begin
      acc        <= '0;
      top_rise_q <= 1'b0;
      tap_rise_q <= 1'b0;
    end else if (step_en) begin
      acc        <= sync_clr ? '0 : sum;
      top_rise_q <= set_bits[TOP];
      tap_rise_q <= set_bits[TAP];
    end else begin
      top_rise_q <= 1'b0;
      tap_rise_q <= 1'b0;
    end
  end

  AST_TEST_HOLDS_ZERO: assert property (@(posedge clk) disable iff (rst)
    step_en && test |=> acc == '0); // R3
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !step_en |=> $stable(acc) && !top_rise_q && !tap_rise_q); // R10
  AST_TOP_FROM_ZERO: assert property (@(posedge clk) disable iff (rst)
    top_rise_q |-> !$past(acc[TOP])); // R4
  AST_TAP_FROM_ZERO: assert property (@(posedge clk) disable iff (rst)
    tap_rise_q |-> !$past(acc[TAP])); // R5
endmodule

// File: rtl/sync_net.sv
module sync_net #(
  parameter int unsigned N = osc_pkg::VOICES_DEF
) (
  input  logic [N-1:0] rise_now,
  input  logic [N-1:0] sync_en,
  output logic [N-1:0] clr
);
  for (genvar g = 0; g < N; g++) begin : g_dst
    localparam int unsigned S  = osc_pkg::ring_src(g, N);
    localparam int unsigned S2 = osc_pkg::ring_src(S, N);
    // a source being cleared itself in this update does not pass the clear on
    assign clr[g] = rise_now[S] && sync_en[g] && !(sync_en[S] && rise_now[S2]);
  end
endmodule

// File: rtl/phase_osc_ring.sv
module phase_osc_ring #(
  parameter int unsigned N    = osc_pkg::VOICES_DEF,
  parameter int unsigned PH_W = osc_pkg::PH_W_DEF,
  parameter int unsigned FQ_W = osc_pkg::FQ_W_DEF,
  parameter int unsigned TAP  = osc_pkg::TAP_DEF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              step_en,
  input  logic [N*FQ_W-1:0] freq,
  input  logic [N-1:0]      test,
  input  logic [N-1:0]      sync_en,
  input  logic [N-1:0]      ring_en,
  output logic [N*PH_W-1:0] phase,
  output logic [N-1:0]      msb_rise,
  output logic [N-1:0]      tap_rise,
  output logic [N-1:0]      ring_msb
);
  localparam int unsigned TOP = PH_W - 1;

  logic [N-1:0] rise_now;
  logic [N-1:0] clr;

  sync_net #(.N(N)) u_sync (
    .rise_now(rise_now),
    .sync_en (sync_en),
    .clr     (clr)
  );

  for (genvar g = 0; g < N; g++) begin : g_voice
    localparam int unsigned S  = osc_pkg::ring_src(g, N);
    localparam int unsigned S2 = osc_pkg::ring_src(S, N);

    phase_acc #(.PH_W(PH_W), .FQ_W(FQ_W), .TAP(TAP)) u_acc (
      .clk         (clk),
      .rst         (rst),
      .step_en     (step_en),
      .test        (test[g]),
      .freq        (freq[g*FQ_W +: FQ_W]),
      .sync_clr    (clr[g]),
      .acc         (phase[g*PH_W +: PH_W]),
      .top_rise_now(rise_now[g]),
      .top_rise_q  (msb_rise[g]),
      .tap_rise_q  (tap_rise[g])
    );

    assign ring_msb[g] = phase[g*PH_W + TOP] ^ (ring_en[g] & phase[S*PH_W + TOP]);

    AST_SYNC_CLEARS: assert property (@(posedge clk) disable iff (rst)
      msb_rise[S] && $past(sync_en[g]) && !($past(sync_en[S]) && msb_rise[S2])
      |-> phase[g*PH_W +: PH_W] == '0); // R6
  end
endmodule

// File: tb/phase_osc_ring_bench.sv
module phase_osc_ring_bench;
  localparam int N = 3;

  typedef struct {
    logic [23:0] ph [3];
    logic [2:0]  mr;
    logic [2:0]  tr;
    logic [2:0]  rm;
    string       req;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic step_en = 1'b0;
  logic [47:0] freq = '0;
  logic [2:0] test = '0, sync_en = '0, ring_en = '0;
  logic [71:0] phase;
  logic [2:0] msb_rise, tap_rise, ring_msb;

  // staging registers set by the test sequence, applied by the driver
  logic s_en = 1'b0;
  logic [15:0] s_fq [3];
  logic [2:0] s_test = '0, s_sync = '0, s_ring = '0;

  logic [23:0] m_ph [3];
  exp_t q[$];
  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  phase_osc_ring u_phase_osc_ring (
    .clk(clk), .rst(rst), .step_en(step_en), .freq(freq), .test(test),
    .sync_en(sync_en), .ring_en(ring_en), .phase(phase),
    .msb_rise(msb_rise), .tap_rise(tap_rise), .ring_msb(ring_msb)
  );

  function automatic int src(input int i);
    return (i + N - 1) % N;
  endfunction

  task automatic step(input int n, input string tag);
    for (int k = 0; k < n; k++) begin
      exp_t e;
      logic [23:0] nx [3];
      logic [2:0] up;
      @(negedge clk); #1;
      step_en = s_en; test = s_test; sync_en = s_sync; ring_en = s_ring;
      for (int i = 0; i < N; i++) freq[i*16 +: 16] = s_fq[i];
      e.mr = '0; e.tr = '0; up = '0;
      for (int i = 0; i < N; i++) begin
        nx[i] = s_test[i] ? 24'h0 : m_ph[i] + {8'h0, s_fq[i]};
        if (s_en) begin
          up[i]   = !m_ph[i][23] && nx[i][23];
          e.tr[i] = !m_ph[i][19] && nx[i][19];
        end
      end
      e.mr = up;
      if (s_en)
        for (int i = 0; i < N; i++) begin
          int s = src(i);
          m_ph[i] = (up[s] && s_sync[i] && !(s_sync[s] && up[src(s)])) ? 24'h0 : nx[i];
        end
      for (int i = 0; i < N; i++) begin
        e.ph[i] = m_ph[i];
      end
      for (int i = 0; i < N; i++)
        e.rm[i] = m_ph[i][23] ^ (s_ring[i] & m_ph[src(i)][23]);
      e.req = tag;
      q.push_back(e);
    end
  endtask

  // monitor: compares one expected item per cycle, away from the active edge
  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      logic ok;
      e = q.pop_front();
      ok = (msb_rise === e.mr) && (tap_rise === e.tr) && (ring_msb === e.rm);
      for (int i = 0; i < N; i++) ok = ok && (phase[i*24 +: 24] === e.ph[i]);
      checks++;
      if (!ok) begin
        fails++;
        $display("FAIL %s: phase=%h msb=%b tap=%b ring=%b expected phase=%h%h%h msb=%b tap=%b ring=%b",
                 e.req, phase, msb_rise, tap_rise, ring_msb,
                 e.ph[2], e.ph[1], e.ph[0], e.mr, e.tr, e.rm);
      end
    end
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < N; i++) begin s_fq[i] = 16'h0; m_ph[i] = 24'h0; end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    checks++; // R1 reset state
    if (phase !== '0 || msb_rise !== '0 || tap_rise !== '0) begin
      fails++;
      $display("FAIL R1: phase=%h msb=%b tap=%b expected all zero", phase, msb_rise, tap_rise);
    end

    // R2: plain accumulation with distinct words, and hold with enable low (R10)
    s_fq[0] = 16'h1234; s_fq[1] = 16'h0100; s_fq[2] = 16'hFFFF;
    s_en = 1'b1; step(20, "R2");
    s_en = 1'b0; step(5, "R2_R10 hold");
    s_en = 1'b1; step(300, "R4_R5 edges and wrap");

    // R3: test clears and holds, restart from zero
    s_test = 3'b111; step(4, "R3_R10 test hold");
    s_test = 3'b000; step(3, "R3 restart");

    // R6: voice 1 follows voice 0 with sync on; R9 ring outputs
    s_test = 3'b111; step(1, "R3");
    s_test = 3'b000; s_fq[0] = 16'hFFFF; s_fq[1] = 16'h0700; s_fq[2] = 16'h0003;
    s_sync = 3'b010; s_ring = 3'b111;
    step(600, "R6_R9 sync");

    // R7: sync off, voice 1 free-runs
    s_sync = 3'b000; s_ring = 3'b010;
    step(300, "R7 no sync");

    // R8: voices 2 and 0 rise together; 0 is cleared, 1 must not be
    s_test = 3'b111; step(1, "R3");
    s_test = 3'b000; s_fq[0] = 16'hFFFF; s_fq[1] = 16'h0300; s_fq[2] = 16'hFFFF;
    s_sync = 3'b011; s_ring = 3'b000;
    step(400, "R8 suppressed sync");

    // mixed enable gaps during sync
    s_sync = 3'b111;
    for (int r = 0; r < 40; r++) begin
      s_en = (r % 3) != 0;
      step(5, "R2_R6_R10 gated");
    end

    repeat (3) @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule